// File: doc/BRIEF.md
# PLL Divider Reprogramming and Lock Sequencer

This block owns the control, divider and fractional registers of an analog PLL and applies new divider settings without glitching the downstream clock more than needed. A command arrives on a valid/ready channel and carries an operation code and a full set of divider values: feedback multiplier m, pre-divider p, post-divider s and signed fractional k. For a rate change the block compares the requested m and p with the programmed values. If they match, s and k are rewritten in place with no interruption. If either differs, it runs a guarded sequence. It holds the PLL in reset, routes the reference around it through bypass and writes the dividers. It then waits a settle time, releases reset and waits for lock with a timeout. On lock it removes the bypass.

The same channel carries power-up and power-down commands. Power-up brings a powered-down PLL through bypass, reset release and lock. Power-down only drops the active-low reset. While a sequence runs the block is busy and deasserts ready, so an upstream source simply holds its command until ready returns. Each command ends with a one-cycle done pulse and an error flag that is set only when lock never arrived. The settle delay and the timeout are given in microseconds and turned into cycle counts from a clock-frequency parameter.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the PLL reset output is 0, bypass is 0, ready is 1, done is 0, the divider word holds the default m=200, p=3, s=1, and the fractional word is 0.
- R2: The control word carries lock input at bit 31, lock-source select at bit 29, a constant 1 at bit 11, the active-low PLL reset at bit 9 and bypass at bit 4, with all other bits 0. The divider word carries m at bits 21:12, p at bits 9:4 and s at bits 2:0, with other bits 0. The fractional word carries k at bits 15:0, with the upper bits 0.
- R3: A rate command (op 0) whose m and p equal the programmed ones writes s and k at the acceptance edge and raises done with no error in the next cycle. PLL reset and bypass do not change.
- R4: A rate command whose m or p differs first clears the PLL reset and sets lock-source select. It then sets bypass, and only after that writes m, p, s and k, while reset is low and bypass is high.
- R5: The PLL reset is released no sooner than SETTLE_US times CLK_MHZ cycles after the m/p write.
- R6: After reset release, a high lock input clears bypass and gives a done pulse with no error.
- R7: If lock does not arrive within LOCK_TIMEOUT_US times CLK_MHZ cycles of reset release, done pulses with the error flag set, bypass stays 1 and reset stays released.
- R8: A power-up command (op 1) while the PLL reset is already 1 changes nothing and gives done with no error in the next cycle.
- R9: A power-up command while the PLL reset is 0 sets bypass, then releases reset, waits for lock and clears bypass.
- R10: A power-down command (op 2) clears the PLL reset in the cycle after acceptance, with done and no error. The enabled output equals the PLL reset bit.
- R11: Ready is 0 while a sequence runs, and a command offered then is neither accepted nor acted on.
- R12: Done is never high in two consecutive cycles, and ready is 0 in the cycle done is high.
- R13: Op code 3 is accepted, changes nothing and gives done with no error in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken this cycle |
| cmd_op_i | input | 2 | 0 rate change, 1 power-up, 2 power-down, 3 no-op |
| cmd_m_i | input | 10 | Requested feedback multiplier |
| cmd_p_i | input | 6 | Requested pre-divider |
| cmd_s_i | input | 3 | Requested post-divider shift |
| cmd_k_i | input | 16 | Requested signed fractional value |
| busy_o | output | 1 | A multi-cycle sequence is running |
| done_o | output | 1 | One-cycle completion pulse |
| done_err_o | output | 1 | With done: lock timed out |
| pll_lock_i | input | 1 | Lock indication from the PLL |
| pll_rst_n_o | output | 1 | Active-low PLL reset / power-down |
| pll_bypass_o | output | 1 | Reference routed around the PLL |
| pll_enabled_o | output | 1 | PLL out of reset |
| ctl_word_o | output | 32 | Control register image |
| div_word_o | output | 32 | Divider register image (m, p, s) |
| frac_word_o | output | 32 | Fractional register image (k) |

## Verification
Rate changes are tried in three forms: m and p unchanged with new s and k, m changed, and p changed alone with a negative k. This separates the in-place path from the relock path and shows that both fields feed the comparison. The lock input is withheld once, which tells a real lock apart from a timeout. Power-up is issued from the enabled and from the powered-down state, and commands are offered during a running sequence. These show the early exit, the full bring-up and back-pressure. Timing between the divider write, reset release and the done pulse is measured to check the settle and timeout windows.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int M_W = 10;
  localparam int P_W = 6;
  localparam int S_W = 3;
  localparam int K_W = 16;
  localparam int WORD_W = 32;

  localparam int M_LSB = 12;
  localparam int P_LSB = 4;
  localparam int S_LSB = 0;
  localparam int K_LSB = 0;

  localparam int LOCK_BIT  = 31;
  localparam int LSEL_BIT  = 29;
  localparam int CLKEN_BIT = 11;
  localparam int RSTN_BIT  = 9;
  localparam int BYP_BIT   = 4;

  typedef enum logic [1:0] {
    OP_RATE = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_NOP  = 2'd3
  } op_e;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [P_W-1:0] p;
    logic [S_W-1:0] s;
    logic [K_W-1:0] k;
  } div_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYP,
    ST_DIV,
    ST_SETTLE,
    ST_REL,
    ST_LOCK
  } st_e;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
  import pll_seq_pkg::*;
#(
  parameter logic [M_W-1:0] RST_M = 10'd200,
  parameter logic [P_W-1:0] RST_P = 6'd3,
  parameter logic [S_W-1:0] RST_S = 3'd1,
  parameter logic [K_W-1:0] RST_K = 16'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_clr_i,
  input  logic              rst_set_i,
  input  logic              lsel_set_i,
  input  logic              byp_set_i,
  input  logic              byp_clr_i,
  input  logic              mp_wr_i,
  input  logic              sk_wr_i,
  input  div_t              nxt_i,
  input  logic              lock_i,
  output logic [M_W-1:0]    cur_m_o,
  output logic [P_W-1:0]    cur_p_o,
  output logic              rstn_o,
  output logic              byp_o,
  output logic [WORD_W-1:0] ctl_word_o,
  output logic [WORD_W-1:0] div_word_o,
  output logic [WORD_W-1:0] frac_word_o
);

  div_t cur_q;
  logic rstn_q, byp_q, lsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '{m: RST_M, p: RST_P, s: RST_S, k: RST_K};
      rstn_q <= 1'b0;
      byp_q  <= 1'b0;
      lsel_q <= 1'b0;
    end else begin
      if (rst_clr_i) begin
        rstn_q <= 1'b0;
      end else if (rst_set_i) begin
        rstn_q <= 1'b1;
      end
      if (byp_set_i) begin
        byp_q <= 1'b1;
      end else if (byp_clr_i) begin
        byp_q <= 1'b0;
      end
      if (lsel_set_i) begin
        lsel_q <= 1'b1;
      end
      if (mp_wr_i) begin
        cur_q.m <= nxt_i.m;
        cur_q.p <= nxt_i.p;
      end
      if (sk_wr_i) begin
        cur_q.s <= nxt_i.s;
        cur_q.k <= nxt_i.k;
      end
    end
  end

  always_comb begin
    ctl_word_o = '0;
    ctl_word_o[LOCK_BIT]  = lock_i;
    ctl_word_o[LSEL_BIT]  = lsel_q;
    ctl_word_o[CLKEN_BIT] = 1'b1;
    ctl_word_o[RSTN_BIT]  = rstn_q;
    ctl_word_o[BYP_BIT]   = byp_q;
  end

  always_comb begin
    div_word_o = '0;
    div_word_o[M_LSB +: M_W] = cur_q.m;
    div_word_o[P_LSB +: P_W] = cur_q.p;
    div_word_o[S_LSB +: S_W] = cur_q.s;
    frac_word_o = '0;
    frac_word_o[K_LSB +: K_W] = cur_q.k;
  end

  assign cur_m_o = cur_q.m;
  assign cur_p_o = cur_q.p;
  assign rstn_o  = rstn_q;
  assign byp_o   = byp_q;

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [1:0]     cmd_op_i,
  input  div_t           cmd_div_i,
  input  logic [M_W-1:0] cur_m_i,
  input  logic [P_W-1:0] cur_p_i,
  input  logic           rstn_i,
  input  logic           lock_i,
  input  logic           tmr_zero_i,
  output logic           cmd_ready_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           done_err_o,
  output logic           rst_clr_o,
  output logic           rst_set_o,
  output logic           lsel_set_o,
  output logic           byp_set_o,
  output logic           byp_clr_o,
  output logic           mp_wr_o,
  output logic           sk_wr_o,
  output logic           tmr_load_o,
  output logic           tmr_tmo_o,
  output div_t           nxt_o
);

  st_e  st_q, st_d;
  div_t held_q;
  logic done_q, err_q;
  logic fin, fin_err, accept, mp_same;

  assign mp_same = (cmd_div_i.m == cur_m_i) && (cmd_div_i.p == cur_p_i);

  always_comb begin
    st_d        = st_q;
    cmd_ready_o = (st_q == ST_IDLE) && !done_q;
    accept      = cmd_valid_i && cmd_ready_o;
    nxt_o       = (st_q == ST_IDLE) ? cmd_div_i : held_q;
    fin         = 1'b0;
    fin_err     = 1'b0;
    rst_clr_o   = 1'b0;
    rst_set_o   = 1'b0;
    lsel_set_o  = 1'b0;
    byp_set_o   = 1'b0;
    byp_clr_o   = 1'b0;
    mp_wr_o     = 1'b0;
    sk_wr_o     = 1'b0;
    tmr_load_o  = 1'b0;
    tmr_tmo_o   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          case (op_e'(cmd_op_i))
            OP_RATE: begin
              if (mp_same) begin
                sk_wr_o = 1'b1;
                fin     = 1'b1;
              end else begin
                rst_clr_o  = 1'b1;
                lsel_set_o = 1'b1;
                st_d       = ST_BYP;
              end
            end
            OP_UP: begin
              if (rstn_i) begin
                fin = 1'b1;
              end else begin
                byp_set_o = 1'b1;
                st_d      = ST_REL;
              end
            end
            OP_DOWN: begin
              rst_clr_o = 1'b1;
              fin       = 1'b1;
            end
            default: fin = 1'b1;
          endcase
        end
      end
      ST_BYP: begin
        byp_set_o = 1'b1;
        st_d      = ST_DIV;
      end
      ST_DIV: begin
        mp_wr_o    = 1'b1;
        sk_wr_o    = 1'b1;
        tmr_load_o = 1'b1;
        st_d       = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (tmr_zero_i) begin
          st_d = ST_REL;
        end
      end
      ST_REL: begin
        rst_set_o  = 1'b1;
        tmr_load_o = 1'b1;
        tmr_tmo_o  = 1'b1;
        st_d       = ST_LOCK;
      end
      ST_LOCK: begin
        if (lock_i) begin
          byp_clr_o = 1'b1;
          fin       = 1'b1;
          st_d      = ST_IDLE;
        end else if (tmr_zero_i) begin
          fin     = 1'b1;
          fin_err = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      held_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      err_q  <= fin_err;
      if (accept) begin
        held_q <= cmd_div_i;
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign done_err_o = err_q;

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int              CLK_MHZ         = 250,
  parameter int              SETTLE_US       = 3,
  parameter int              LOCK_TIMEOUT_US = 10000,
  parameter logic [M_W-1:0]  RST_M           = 10'd200,
  parameter logic [P_W-1:0]  RST_P           = 6'd3,
  parameter logic [S_W-1:0]  RST_S           = 3'd1,
  parameter logic [K_W-1:0]  RST_K           = 16'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [M_W-1:0]    cmd_m_i,
  input  logic [P_W-1:0]    cmd_p_i,
  input  logic [S_W-1:0]    cmd_s_i,
  input  logic [K_W-1:0]    cmd_k_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_err_o,
  input  logic              pll_lock_i,
  output logic              pll_rst_n_o,
  output logic              pll_bypass_o,
  output logic              pll_enabled_o,
  output logic [WORD_W-1:0] ctl_word_o,
  output logic [WORD_W-1:0] div_word_o,
  output logic [WORD_W-1:0] frac_word_o
);

  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int TMO_CYC    = LOCK_TIMEOUT_US * CLK_MHZ;
  localparam int MAX_CYC    = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  div_t             cmd_div, nxt;
  logic [M_W-1:0]   cur_m;
  logic [P_W-1:0]   cur_p;
  logic             rstn, byp;
  logic             rst_clr, rst_set, lsel_set, byp_set, byp_clr, mp_wr, sk_wr;
  logic             tmr_load, tmr_tmo, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  assign cmd_div = '{m: cmd_m_i, p: cmd_p_i, s: cmd_s_i, k: cmd_k_i};
  assign tmr_val = tmr_tmo ? CNT_W'(TMO_CYC) : CNT_W'(SETTLE_CYC);

  pll_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_div_i   (cmd_div),
    .cur_m_i     (cur_m),
    .cur_p_i     (cur_p),
    .rstn_i      (rstn),
    .lock_i      (pll_lock_i),
    .tmr_zero_i  (tmr_zero),
    .cmd_ready_o (cmd_ready_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .done_err_o  (done_err_o),
    .rst_clr_o   (rst_clr),
    .rst_set_o   (rst_set),
    .lsel_set_o  (lsel_set),
    .byp_set_o   (byp_set),
    .byp_clr_o   (byp_clr),
    .mp_wr_o     (mp_wr),
    .sk_wr_o     (sk_wr),
    .tmr_load_o  (tmr_load),
    .tmr_tmo_o   (tmr_tmo),
    .nxt_o       (nxt)
  );

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  pll_seq_regs #(
    .RST_M (RST_M),
    .RST_P (RST_P),
    .RST_S (RST_S),
    .RST_K (RST_K)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_clr_i   (rst_clr),
    .rst_set_i   (rst_set),
    .lsel_set_i  (lsel_set),
    .byp_set_i   (byp_set),
    .byp_clr_i   (byp_clr),
    .mp_wr_i     (mp_wr),
    .sk_wr_i     (sk_wr),
    .nxt_i       (nxt),
    .lock_i      (pll_lock_i),
    .cur_m_o     (cur_m),
    .cur_p_o     (cur_p),
    .rstn_o      (rstn),
    .byp_o       (byp),
    .ctl_word_o  (ctl_word_o),
    .div_word_o  (div_word_o),
    .frac_word_o (frac_word_o)
  );

  assign pll_rst_n_o   = rstn;
  assign pll_bypass_o  = byp;
  assign pll_enabled_o = rstn;

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int SETTLE_CYC = 750
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic [1:0] cmd_op_i,
  input logic [9:0] cmd_m_i,
  input logic [5:0] cmd_p_i,
  input logic [9:0] cur_m,
  input logic [5:0] cur_p,
  input logic       pll_lock_i,
  input logic       pll_rst_n_o,
  input logic       pll_bypass_o,
  input logic       done_o,
  input logic       done_err_o
);

  localparam int CW = $clog2(SETTLE_CYC + 2);
  localparam logic [CW-1:0] SETTLE_L = CW'(SETTLE_CYC);

  logic [15:0]   mp_q;
  logic [CW-1:0] since_q;
  logic          mp_chg, acc;

  assign mp_chg = ({cur_m, cur_p} != mp_q);
  assign acc    = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mp_q    <= {cur_m, cur_p};
      since_q <= SETTLE_L;
    end else begin
      mp_q <= {cur_m, cur_p};
      if (mp_chg) begin
        since_q <= '0;
      end else if (since_q < SETTLE_L) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  p_fast_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 2'd0 && cmd_m_i == cur_m && cmd_p_i == cur_p)
      |=> ($stable(pll_rst_n_o) && $stable(pll_bypass_o) && done_o && !done_err_o));

  p_div_guarded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mp_chg |-> (!pll_rst_n_o && pll_bypass_o));

  p_settle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_rst_n_o) |-> (since_q >= SETTLE_L));

  p_lock_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_bypass_o) |-> ($past(pll_lock_i) && pll_rst_n_o && done_o && !done_err_o));

  p_tmo_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_err_o) |-> (pll_bypass_o && pll_rst_n_o));

  p_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 2'd2) |=> (!pll_rst_n_o && done_o && !done_err_o));

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ready_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_ready_o);

endmodule

bind pll_reprog_seq pll_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .cmd_op_i     (cmd_op_i),
  .cmd_m_i      (cmd_m_i),
  .cmd_p_i      (cmd_p_i),
  .cur_m        (cur_m),
  .cur_p        (cur_p),
  .pll_lock_i   (pll_lock_i),
  .pll_rst_n_o  (pll_rst_n_o),
  .pll_bypass_o (pll_bypass_o),
  .done_o       (done_o),
  .done_err_o   (done_err_o)
);

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;

  localparam int CLK_MHZ   = 250;
  localparam int SETTLE_US = 3;
  localparam int TMO_US    = 4;
  localparam int SET_CYC   = SETTLE_US * CLK_MHZ;
  localparam int TMO_CYC   = TMO_US * CLK_MHZ;
  localparam int LOCK_DLY  = 40;
  localparam int PER_NS    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [9:0]  cmd_m = '0;
  logic [5:0]  cmd_p = '0;
  logic [2:0]  cmd_s = '0;
  logic [15:0] cmd_k = '0;
  logic        cmd_ready, busy, done, done_err, pll_lock;
  logic        pll_rst_n, pll_bypass, pll_enabled;
  logic [31:0] ctl_word, div_word, frac_word;

  always #2 clk = ~clk;

  pll_reprog_seq #(
    .CLK_MHZ         (CLK_MHZ),
    .SETTLE_US       (SETTLE_US),
    .LOCK_TIMEOUT_US (TMO_US)
  ) u_pll_reprog_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cmd_valid_i   (cmd_valid),
    .cmd_ready_o   (cmd_ready),
    .cmd_op_i      (cmd_op),
    .cmd_m_i       (cmd_m),
    .cmd_p_i       (cmd_p),
    .cmd_s_i       (cmd_s),
    .cmd_k_i       (cmd_k),
    .busy_o        (busy),
    .done_o        (done),
    .done_err_o    (done_err),
    .pll_lock_i    (pll_lock),
    .pll_rst_n_o   (pll_rst_n),
    .pll_bypass_o  (pll_bypass),
    .pll_enabled_o (pll_enabled),
    .ctl_word_o    (ctl_word),
    .div_word_o    (div_word),
    .frac_word_o   (frac_word)
  );

  // analog PLL model: lock after LOCK_DLY cycles out of reset unless blocked
  int   lcnt = 0;
  logic lock_q = 1'b0;
  bit   block_lock = 1'b0;
  always @(posedge clk) begin
    if (!pll_rst_n) begin
      lcnt   <= 0;
      lock_q <= 1'b0;
    end else if (block_lock) begin
      lock_q <= 1'b0;
    end else begin
      if (lcnt < LOCK_DLY) lcnt <= lcnt + 1;
      lock_q <= (lcnt >= LOCK_DLY);
    end
  end
  assign pll_lock = lock_q;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_div(logic [9:0] m, logic [5:0] p, logic [2:0] s);
    return {10'd0, m, 2'd0, p, 1'b0, s};
  endfunction

  typedef struct {
    string       req;
    bit          err;
    logic [31:0] div;
    logic [31:0] frac;
    bit          rstn;
    bit          byp;
  } exp_t;

  exp_t sbq[$];
  int   n_done = 0;
  time  t_done = 0;
  logic prev_done = 1'b0;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk("R12 done pulse width", 32'd1, 32'd0);
      if (done) begin
        t_done = $time;
        n_done++;
        if (sbq.size() == 0) begin
          chk("R11 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk({e.req, " err"},  {31'd0, done_err},   {31'd0, e.err});
          chk({e.req, " div"},  div_word,            e.div);
          chk({e.req, " frac"}, frac_word,           e.frac);
          chk({e.req, " rstn"}, {31'd0, pll_rst_n},  {31'd0, e.rstn});
          chk({e.req, " byp"},  {31'd0, pll_bypass}, {31'd0, e.byp});
        end
      end
      prev_done = done;
    end
  end

  // sequence watcher
  logic [15:0] prev_mp = '0;
  logic        prev_rstn = 1'b0;
  time         t_div = 0, t_rel = 0;
  bit          order_ok = 1'b1;
  bit          byp_at_rise = 1'b0;
  int          n_mpchg = 0, n_rstfall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ({div_word[21:12], div_word[9:4]} != prev_mp) begin
        t_div = $time;
        n_mpchg++;
        order_ok = !pll_rst_n && pll_bypass && ctl_word[29];
      end
      if (pll_rst_n && !prev_rstn) begin
        t_rel = $time;
        byp_at_rise = pll_bypass;
      end
      if (!pll_rst_n && prev_rstn) n_rstfall++;
    end
    prev_mp   = {div_word[21:12], div_word[9:4]};
    prev_rstn = pll_rst_n;
  end

  task automatic issue(input logic [1:0] op, input logic [9:0] m, input logic [5:0] p,
                       input logic [2:0] s, input logic [15:0] k, input exp_t e);
    sbq.push_back(e);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op; cmd_m = m; cmd_p = p; cmd_s = s; cmd_k = k;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (n_done < target) @(negedge clk);
  endtask

  function automatic exp_t mk(string req, bit err, logic [31:0] dv, logic [31:0] fr,
                              bit rn, bit bp);
    exp_t e;
    e.req = req; e.err = err; e.div = dv; e.frac = fr; e.rstn = rn; e.byp = bp;
    return e;
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rf, mc;
    bit bad;
    time gap;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rst_n", {31'd0, pll_rst_n}, 32'd0);
    chk("R1 bypass", {31'd0, pll_bypass}, 32'd0);
    chk("R1 ready", {31'd0, cmd_ready}, 32'd1);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 div", div_word, pack_div(10'd200, 6'd3, 3'd1));
    chk("R1 frac", frac_word, 32'd0);
    // R2 control word layout at reset
    chk("R2 ctl reset", ctl_word, 32'h0000_0800);

    // R9 power-up from powered-down
    issue(2'd1, '0, '0, '0, '0, mk("R9 up", 0, pack_div(10'd200, 6'd3, 3'd1), 32'd0, 1, 0));
    wait_done(1);
    chk("R9 bypass at release", {31'd0, byp_at_rise}, 32'd1);
    @(negedge clk);
    chk("R2 ctl after up", ctl_word, 32'h8000_0A00);

    // R8 power-up while enabled
    rf = n_rstfall;
    issue(2'd1, '0, '0, '0, '0, mk("R8 up again", 0, pack_div(10'd200, 6'd3, 3'd1), 32'd0, 1, 0));
    chk("R8 done next cycle", {31'd0, done}, 32'd1);
    chk("R8 no reset", n_rstfall, rf);
    wait_done(2);

    // R3 in-place s/k update
    rf = n_rstfall; mc = n_mpchg;
    issue(2'd0, 10'd200, 6'd3, 3'd2, 16'h1234,
          mk("R3 fast", 0, pack_div(10'd200, 6'd3, 3'd2), 32'h0000_1234, 1, 0));
    chk("R3 done next cycle", {31'd0, done}, 32'd1);
    wait_done(3);
    chk("R3 no reset", n_rstfall, rf);
    chk("R3 no m/p change", n_mpchg, mc);

    // R4 R5 R6 m change
    rf = n_rstfall;
    issue(2'd0, 10'd300, 6'd3, 3'd1, 16'h0000,
          mk("R6 relock m", 0, pack_div(10'd300, 6'd3, 3'd1), 32'd0, 1, 0));
    wait_done(4);
    chk("R4 order m", {31'd0, order_ok}, 32'd1);
    chk("R4 one reset", n_rstfall, rf + 1);
    gap = t_rel - t_div;
    chk("R5 settle m", {31'd0, gap >= time'(SET_CYC * PER_NS)}, 32'd1);
    @(negedge clk);
    chk("R2 ctl lock select", ctl_word, 32'hA000_0A00);

    // R4 R5 p-only change with negative k
    rf = n_rstfall;
    issue(2'd0, 10'd300, 6'd2, 3'd2, 16'hC000,
          mk("R6 relock p", 0, pack_div(10'd300, 6'd2, 3'd2), 32'h0000_C000, 1, 0));
    wait_done(5);
    chk("R4 order p", {31'd0, order_ok}, 32'd1);
    chk("R4 p reset", n_rstfall, rf + 1);
    gap = t_rel - t_div;
    chk("R5 settle p", {31'd0, gap >= time'(SET_CYC * PER_NS)}, 32'd1);

    // R11 commands offered while busy
    issue(2'd0, 10'd250, 6'd3, 3'd0, 16'h0010,
          mk("R11 busy relock", 0, pack_div(10'd250, 6'd3, 3'd0), 32'h0000_0010, 1, 0));
    bad = 1'b0;
    cmd_op = 2'd2;
    for (int i = 0; i < 20; i++) begin
      cmd_valid = 1'b1;
      @(negedge clk);
      if (cmd_ready) bad = 1'b1;
    end
    cmd_valid = 1'b0;
    chk("R11 ready low when busy", {31'd0, bad}, 32'd0);
    wait_done(6);
    chk("R11 down ignored", {31'd0, pll_rst_n}, 32'd1);

    // R7 lock timeout
    block_lock = 1'b1;
    issue(2'd0, 10'd260, 6'd3, 3'd0, 16'h0000,
          mk("R7 timeout", 1, pack_div(10'd260, 6'd3, 3'd0), 32'd0, 1, 1));
    wait_done(7);
    gap = t_done - t_rel;
    chk("R7 window low", {31'd0, gap >= time'(TMO_CYC * PER_NS)}, 32'd1);
    chk("R7 window high", {31'd0, gap <= time'((TMO_CYC + 8) * PER_NS)}, 32'd1);
    block_lock = 1'b0;

    // R10 power-down
    issue(2'd2, '0, '0, '0, '0, mk("R10 down", 0, pack_div(10'd260, 6'd3, 3'd0), 32'd0, 0, 1));
    chk("R10 done next cycle", {31'd0, done}, 32'd1);
    chk("R10 enabled", {31'd0, pll_enabled}, 32'd0);
    wait_done(8);

    // R9 bring-up after down clears bypass
    issue(2'd1, '0, '0, '0, '0, mk("R9 up after down", 0, pack_div(10'd260, 6'd3, 3'd0), 32'd0, 1, 0));
    wait_done(9);
    chk("R9 bypass at release 2", {31'd0, byp_at_rise}, 32'd1);
    chk("R10 enabled follows reset", {31'd0, pll_enabled}, 32'd1);

    // R13 no-op code
    rf = n_rstfall;
    issue(2'd3, 10'd7, 6'd7, 3'd7, 16'h7777,
          mk("R13 nop", 0, pack_div(10'd260, 6'd3, 3'd0), 32'd0, 1, 0));
    chk("R13 done next cycle", {31'd0, done}, 32'd1);
    wait_done(10);
    chk("R13 no reset", n_rstfall, rf);

    repeat (4) @(negedge clk);
    chk("R12 scoreboard drained", sbq.size(), 32'd0);
    finish_run();
  end

endmodule